// File: doc/BRIEF.md
# Output-Toggling Reload Down-Timer

A 24-bit down-counting timer. A system clock runs its registers, and a single-cycle count strobe in the same clock domain advances its count. Software controls it through three write ports. The first writes the counter. The second writes the reload register. The third is a control write that carries an enable bit, a mode bit and an initial level for the output flip-flop. In one-shot mode the timer makes a single pulse and then goes idle. In continuous mode it reloads after every underflow and keeps running until it is disabled.

The output flip-flop inverts on the strobe that starts the timer and on every underflow strobe. Each underflow also raises an interrupt request and a DMA request. Both requests are high for exactly the clock cycle in which the underflow strobe occurs. An enable write takes effect only on the next count strobe, so there is up to one count period of delay before counting starts and before the startup inversion.

The sequencer has five states:
- IDLE: stopped.
- ARMED: enabled, waiting for the first strobe.
- LOADED: one-shot hold strobe after the load.
- RUN: counting down.
- RELOAD: continuous-mode strobe after an underflow.

Its transitions are:
- IDLE→ARMED on an enable write.
- ARMED→LOADED on a strobe in one-shot mode.
- ARMED→RUN on a strobe in continuous mode.
- LOADED→RUN on a strobe.
- RUN→IDLE on a one-shot underflow.
- RUN→RELOAD on a continuous underflow.
- RELOAD→RUN on a strobe.
- any state→IDLE on a disable write.

Top module: `reload_down_timer`

## Requirements
- R1: After reset the counter, reload register, flip-flop output, both request outputs and the running status are all 0.
- R2: A control write with enable=1 from IDLE sets running=1 in the following cycle. The counter and flip-flop do not change until a count strobe arrives.
- R3: On the first strobe after enabling, ff_out inverts. In one-shot mode (ctl_mode=0) the counter loads reload−1 on that strobe.
- R4: In one-shot mode, the strobe after the load holds the count and later strobes decrement it. The strobe that finds the count at 0 is the underflow: ff_out inverts, the counter stays 0, and running returns to 0. The two inversions are reload+1 strobes apart.
- R5: In continuous mode (ctl_mode=1) the counter is not loaded at start. The first underflow comes C+1 strobes after the start strobe, where C is the value software wrote into the counter.
- R6: In continuous mode, the strobe after an underflow loads reload−1. Underflows then repeat every reload+1 strobes until the timer is disabled.
- R7: irq_req and dma_req are identical. They are high only during a cycle whose count strobe is an underflow, and they are high once per underflow.
- R8: A control write with enable=0 stops the timer immediately. The counter and ff_out then hold their values, and no further request pulse occurs.
- R9: A control write made while IDLE loads ctl_init_lvl into ff_out.
- R10: If a disable write falls on the same cycle as an underflow strobe, the disable wins: no request pulse, no inversion, and running clears.
- R11: A counter write takes priority over a reload load or a decrement in the same cycle.
- R12: Without a count strobe and without writes, the counter and ff_out do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_tick | input | 1 | Single-cycle count strobe |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 24 | Counter write value |
| rld_we | input | 1 | Reload register write strobe |
| rld_wdata | input | 24 | Reload write value |
| ctl_we | input | 1 | Control write strobe |
| ctl_en | input | 1 | Enable bit of the control write |
| ctl_mode | input | 1 | 0 one-shot, 1 continuous |
| ctl_init_lvl | input | 1 | Flip-flop level loaded while idle |
| count_q | output | 24 | Current counter value |
| ff_out | output | 1 | Toggling flip-flop output |
| irq_req | output | 1 | Interrupt request pulse |
| dma_req | output | 1 | DMA transfer request pulse |
| running | output | 1 | High while the sequencer is not idle |

## Verification
An underflow strobe and a software disable write can land in the same cycle. The bench provokes this by stepping its model until the sequencer is in RUN with the count at 0, then issuing the strobe and the disable write together. It judges the result by three observations: no request pulse in that cycle, an unchanged ff_out afterwards, and a cleared running status. The same collision, and a counter write coinciding with a reload or decrement, also come up in the randomized phase, where every cycle is compared against the bench model.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARMED  = 3'd1,
        ST_LOADED = 3'd2,
        ST_RUN    = 3'd3,
        ST_RELOAD = 3'd4
    } rdt_state_e;

    typedef enum logic {
        MODE_ONESHOT    = 1'b0,
        MODE_CONTINUOUS = 1'b1
    } rdt_mode_e;
endpackage

// File: rtl/rdt_ctrl_fsm.sv
module rdt_ctrl_fsm
    import rdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       ctl_we,
    input  logic       ctl_en,
    input  logic       ctl_mode,
    input  logic       cnt_zero,
    output rdt_state_e state_o,
    output logic       start_o,
    output logic       load_o,
    output logic       dec_o,
    output logic       uf_o,
    output logic       init_we_o
);
    rdt_state_e state_q, state_d;
    rdt_mode_e  mode_q, mode_d;
    logic       stop_req;
    logic       arm_req;

    // A disable write wins over any strobe; an enable write arms only from idle.
    assign stop_req = ctl_we && !ctl_en;
    assign arm_req  = ctl_we && ctl_en && (state_q == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_ONESHOT;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
        end
    end

    // Next-state process
    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        if (stop_req) begin
            state_d = ST_IDLE;
        end else if (arm_req) begin
            state_d = ST_ARMED;
            mode_d  = rdt_mode_e'(ctl_mode);
        end else if (tick) begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_ARMED:  state_d = (mode_q == MODE_ONESHOT) ? ST_LOADED : ST_RUN;
                ST_LOADED: state_d = ST_RUN;
                ST_RUN: begin
                    if (cnt_zero)
                        state_d = (mode_q == MODE_ONESHOT) ? ST_IDLE : ST_RELOAD;
                end
                ST_RELOAD: state_d = ST_RUN;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // Output process
    always_comb begin
        start_o   = 1'b0;
        load_o    = 1'b0;
        dec_o     = 1'b0;
        uf_o      = 1'b0;
        init_we_o = ctl_we && (state_q == ST_IDLE);
        if (tick && !stop_req) begin
            unique case (state_q)
                ST_IDLE:   ;
                ST_ARMED: begin
                    start_o = 1'b1;
                    load_o  = (mode_q == MODE_ONESHOT);
                end
                ST_LOADED: ;
                ST_RUN: begin
                    uf_o  = cnt_zero;
                    dec_o = !cnt_zero;
                end
                ST_RELOAD: load_o = 1'b1;
                default:   ;
            endcase
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/rdt_counter.sv
module rdt_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             rld_we,
    input  logic [CNT_W-1:0] rld_data,
    input  logic             load,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             zero
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rld_q <= '0;
        end else if (rld_we) begin
            rld_q <= rld_data;
        end
    end

    // Software write beats reload and decrement.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_en) begin
            cnt_q <= wr_data;
        end else if (load) begin
            cnt_q <= rld_q - ONE;
        end else if (dec) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign count = cnt_q;
    assign zero  = (cnt_q == '0);
endmodule

// File: rtl/rdt_toggle.sv
module rdt_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic init_we,
    input  logic init_lvl,
    input  logic flip,
    output logic q
);
    logic q_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r <= 1'b0;
        end else if (init_we) begin
            q_r <= init_lvl;
        end else if (flip) begin
            q_r <= ~q_r;
        end
    end

    assign q = q_r;
endmodule

// File: rtl/reload_down_timer.sv
module reload_down_timer
    import rdt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_tick,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             rld_we,
    input  logic [CNT_W-1:0] rld_wdata,
    input  logic             ctl_we,
    input  logic             ctl_en,
    input  logic             ctl_mode,
    input  logic             ctl_init_lvl,
    output logic [CNT_W-1:0] count_q,
    output logic             ff_out,
    output logic             irq_req,
    output logic             dma_req,
    output logic             running
);
    rdt_state_e state;
    logic start, load, dec, uf, init_we, zero;

    rdt_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (cnt_tick),
        .ctl_we    (ctl_we),
        .ctl_en    (ctl_en),
        .ctl_mode  (ctl_mode),
        .cnt_zero  (zero),
        .state_o   (state),
        .start_o   (start),
        .load_o    (load),
        .dec_o     (dec),
        .uf_o      (uf),
        .init_we_o (init_we)
    );

    rdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cnt_we),
        .wr_data  (cnt_wdata),
        .rld_we   (rld_we),
        .rld_data (rld_wdata),
        .load     (load),
        .dec      (dec),
        .count    (count_q),
        .zero     (zero)
    );

    rdt_toggle u_ff (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_we  (init_we),
        .init_lvl (ctl_init_lvl),
        .flip     (start || uf),
        .q        (ff_out)
    );

    assign irq_req = uf;
    assign dma_req = uf;
    assign running = (state != ST_IDLE);
endmodule

// File: rtl/rdt_checker.sv
module rdt_checker #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_tick,
    input logic             cnt_we,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic             ctl_we,
    input logic             ctl_en,
    input logic [CNT_W-1:0] count_q,
    input logic             ff_out,
    input logic             irq_req,
    input logic             dma_req,
    input logic             running
);
    AST_REQ_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == dma_req); // R7
    AST_REQ_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (cnt_tick && running)); // R7
    AST_UF_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> (ff_out != $past(ff_out))); // R4
    AST_STOP_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !ctl_en) |=> !running); // R8
    AST_STOP_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !ctl_en) |-> !irq_req); // R10
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (count_q == $past(cnt_wdata))); // R11
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_tick && !cnt_we && !ctl_we) |=> ($stable(count_q) && $stable(ff_out))); // R12
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cnt_we && !ctl_we) |=> $stable(count_q)); // R8
endmodule

bind reload_down_timer rdt_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/reload_down_timer_test.sv
`timescale 1ns/1ps
module reload_down_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_tick = 1'b0, cnt_we = 1'b0, rld_we = 1'b0;
    logic        ctl_we = 1'b0, ctl_en = 1'b0, ctl_mode = 1'b0, ctl_init_lvl = 1'b0;
    logic [23:0] cnt_wdata = '0, rld_wdata = '0;
    logic [23:0] count_q;
    logic        ff_out, irq_req, dma_req, running;

    int total = 0, bad = 0;
    int tick_no = 0, last_tog = -1, prev_tog = -1, irq_seen = 0;
    // bench model: phase 0 idle, 1 armed, 2 loaded, 3 run, 4 reload
    int          m_ph = 0;
    logic [23:0] m_cnt = '0, m_rld = '0;
    logic        m_ff = 1'b0, m_mode = 1'b0;

    always #5 clk = ~clk;

    reload_down_timer uut (.*);

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic step(bit tk, bit cw, bit cen, bit cmode, bit cinit,
                        bit nw, logic [23:0] nd, bit rw, logic [23:0] rd);
        bit stop, uf, tog, load, dec;
        int n_ph;
        cnt_tick = tk; ctl_we = cw; ctl_en = cen; ctl_mode = cmode;
        ctl_init_lvl = cinit; cnt_we = nw; cnt_wdata = nd; rld_we = rw; rld_wdata = rd;
        #1;
        stop = cw && !cen;
        uf = !stop && tk && m_ph == 3 && m_cnt == 0;
        chk(irq_req == uf, "R7 irq", 32'(irq_req), 32'(uf));
        chk(dma_req == uf, "R7 dma", 32'(dma_req), 32'(uf));
        chk(count_q == m_cnt, "R11 count", 32'(count_q), 32'(m_cnt));
        chk(ff_out == m_ff, "R3 ff", 32'(ff_out), 32'(m_ff));
        chk(running == (m_ph != 0), "R2 running", 32'(running), 32'(m_ph != 0));
        if (irq_req) irq_seen++;
        n_ph = m_ph; tog = 0; load = 0; dec = 0;
        if (stop) n_ph = 0;
        else if (cw && cen && m_ph == 0) begin n_ph = 1; m_mode = cmode; end
        else if (tk) begin
            case (m_ph)
                1: begin tog = 1; if (!m_mode) begin load = 1; n_ph = 2; end else n_ph = 3; end
                2: n_ph = 3;
                3: if (m_cnt == 0) begin tog = 1; n_ph = m_mode ? 4 : 0; end else dec = 1;
                4: begin load = 1; n_ph = 3; end
                default: ;
            endcase
        end
        if (cw && m_ph == 0) m_ff = cinit;
        else if (tog) m_ff = ~m_ff;
        if (nw) m_cnt = nd;
        else if (load) m_cnt = m_rld - 24'd1;
        else if (dec) m_cnt = m_cnt - 24'd1;
        if (rw) m_rld = rd;
        if (tog) begin prev_tog = last_tog; last_tog = tick_no; end
        if (tk) tick_no++;
        m_ph = n_ph;
        @(negedge clk);
        cnt_tick = 0; ctl_we = 0; cnt_we = 0; rld_we = 0;
    endtask

    task automatic idle_tick(int n);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0, '0, 0, '0);
    endtask

    initial begin
        #1_500_000;
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [23:0] c_hold;
        logic        f_hold;
        int          t0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(count_q == 0 && ff_out == 0 && !irq_req && !dma_req && !running,
            "R1 reset", {count_q, 5'd0, ff_out, irq_req, running}, 0);

        // R9 idle control write sets init level
        step(0, 1, 0, 0, 1, 0, '0, 0, '0);
        chk(ff_out == 1'b1, "R9 init level", 32'(ff_out), 1);

        // R12 no strobe, no writes
        step(0, 0, 0, 0, 0, 1, 24'h00_0055, 0, '0);
        c_hold = count_q; f_hold = ff_out;
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, '0, 0, '0);
        chk(count_q == c_hold && ff_out == f_hold, "R12 hold", 32'(count_q), 32'(c_hold));

        // one-shot, reload 3
        step(0, 0, 0, 0, 0, 0, '0, 1, 24'd3);
        step(0, 1, 1, 0, 0, 0, '0, 0, '0);
        chk(running && ff_out == 0 && count_q == 24'h55, "R2 armed, no change",
            {count_q, 7'd0, running}, {24'h55, 8'd1});
        step(0, 0, 0, 0, 0, 0, '0, 0, '0);
        chk(ff_out == 0, "R2 waits strobe", 32'(ff_out), 0);
        irq_seen = 0;
        idle_tick(1);
        chk(ff_out == 1 && count_q == 24'd2, "R3 start", {count_q, 7'd0, ff_out}, {24'd2, 8'd1});
        idle_tick(6);
        chk(last_tog - prev_tog == 4, "R4 width", 32'(last_tog - prev_tog), 4);
        chk(!running && count_q == 0 && ff_out == 0, "R4 stopped", {count_q, 7'd0, running}, 0);
        chk(irq_seen == 1, "R7 one pulse", 32'(irq_seen), 1);

        // continuous, counter 2, reload 3
        step(0, 0, 0, 0, 0, 1, 24'd2, 0, '0);
        step(0, 1, 1, 1, 0, 0, '0, 0, '0);
        idle_tick(1);
        t0 = last_tog;
        idle_tick(3);
        chk(last_tog - t0 == 3, "R5 first underflow", 32'(last_tog - t0), 3);
        idle_tick(4);
        chk(last_tog - prev_tog == 4, "R6 period", 32'(last_tog - prev_tog), 4);
        idle_tick(4);
        chk(last_tog - prev_tog == 4, "R6 period again", 32'(last_tog - prev_tog), 4);

        // R11 counter write on a strobe while running
        step(1, 0, 0, 0, 0, 1, 24'h000123, 0, '0);
        chk(count_q == 24'h000123, "R11 write wins", 32'(count_q), 32'h123);

        // R8 disable mid-run freezes
        step(0, 1, 0, 0, 0, 0, '0, 0, '0);
        c_hold = count_q; f_hold = ff_out; irq_seen = 0;
        idle_tick(6);
        chk(count_q == c_hold && ff_out == f_hold && irq_seen == 0 && !running,
            "R8 frozen", 32'(count_q), 32'(c_hold));

        // R10 disable collides with underflow
        step(0, 0, 0, 0, 0, 1, 24'd1, 0, '0);
        step(0, 1, 1, 1, 0, 0, '0, 0, '0);
        while (!(m_ph == 3 && m_cnt == 0)) idle_tick(1);
        f_hold = ff_out;
        step(1, 1, 0, 0, 0, 0, '0, 0, '0);
        chk(ff_out == f_hold && !running, "R10 disable wins", 32'(ff_out), 32'(f_hold));

        // randomized phase against the model
        for (int i = 0; i < 4000; i++) begin
            bit tk, cw, nw, rw;
            tk = ($urandom % 2) == 0;
            cw = ($urandom % 23) == 0;
            nw = ($urandom % 37) == 0;
            rw = ($urandom % 19) == 0;
            step(tk, cw, ($urandom % 3) != 0, $urandom % 2, $urandom % 2,
                 nw, 24'($urandom % 6), rw, 24'(1 + $urandom % 6));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule